// File: doc/BRIEF.md
# Power Control Register Bank

This block holds the software-visible controls and status flags of a power management unit. A simple peripheral bus reaches two 32-bit registers. The control word carries the deep-sleep mode selects, the flash power-down-in-stop bit, the supply-monitor enable and its 3-bit level code, the backup-domain write unlock, and two self-clearing commands that clear the hardware flags. The status word carries the backup regulator enable and the wake-pin enable, and it shows four hardware states: the standby flag, the wakeup flag, backup regulator ready and the monitor comparator output. The analog comparators and regulators sit outside the block. Their state arrives on input pins, and the stored fields leave on output pins.

Three reset inputs cover the separate reset domains. `por_rst` is the power-on/power-down reset and clears everything. `sys_rst` is the system reset. `stby_rst` is the standby-exit reset. Each field obeys only the resets of its own domain. Two state machines organise the block. The bus machine (`BUS_IDLE`, `BUS_STAT_WAIT`) adds one wait cycle to status reads. Its transitions are `BUS_IDLE -> BUS_STAT_WAIT` on the first access cycle of a status read, and `BUS_STAT_WAIT -> BUS_IDLE` on the next cycle. The wakeup-clear machine (`CLR_IDLE`, `CLR_PEND`) delays the wakeup-flag clear by `CLR_DELAY` cycles. Its transitions are `CLR_IDLE -> CLR_PEND` on a clear-wakeup command. `CLR_PEND -> CLR_PEND` restarts the count when a new command arrives. `CLR_PEND -> CLR_IDLE` occurs when the count ends, and that edge clears the flag.

Top module: `pcr_bank`

## Requirements
- R1: After `por_rst` every register reads zero: control at offset 0x0, status at offset 0x4, and any unmapped offset. The bank outputs are also zero.
- R2: Control word layout: bit 9 flash power-down in stop, bit 8 backup write unlock, bits 7:5 monitor level, bit 4 monitor enable, bit 3 clear-standby command, bit 2 clear-wakeup command, bit 1 deep-sleep power-down select, bit 0 low-power regulator in stop. Bits 3 and 2 and bits 31:10 always read 0.
- R3: `psize` encodes 0 = byte, 1 = half-word, 2 = word and 3 = reserved. A write takes effect only if it is a word or half-word access at an offset with bits 1:0 equal to 0. A half-word write to bits 1:0 = 2 selects the upper 16 bits, which hold nothing, so it has no effect. A byte write, a reserved-size write or a misaligned write is ignored and completes without error.
- R4: Status bit 9 (backup regulator enable) changes on a write only while the control word's bit 8 is 1 before that write. Only `por_rst` clears status bit 9.
- R5: A committed write of 1 to control bit 3 clears the standby flag (status bit 1) at the commit edge. Writing 0 to bit 3 leaves the flag unchanged.
- R6: A committed write of 1 to control bit 2 clears the wakeup flag (status bit 0) exactly `CLR_DELAY` clock edges after the commit edge.
- R7: `sys_rst` clears the control word, the wake-pin enable (status bit 8) and the wakeup flag. It keeps the standby flag and the backup regulator enable.
- R8: `stby_rst` clears the control word only. All status fields keep their values.
- R9: Status bit 2 shows `mon_out_in` only while the monitor enable (control bit 4) is 1, and otherwise reads 0. Status bit 3 always shows `bkreg_ready_in`. Status bits 7:4 read 0.
- R10: A status read holds `pready` low for its first access cycle and raises it on the second. Control reads, unmapped reads and all writes complete in their first access cycle.
- R11: A pulse on `set_standby` or `set_wakeup` sets its flag. When a set and a clear command fall on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_rst | input | 1 | Power-on/power-down reset, synchronous, active high |
| sys_rst | input | 1 | System reset, synchronous, active high |
| stby_rst | input | 1 | Standby-exit reset, synchronous, active high |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset |
| psize | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Access completes this cycle |
| set_standby | input | 1 | Hardware pulse that sets the standby flag |
| set_wakeup | input | 1 | Hardware pulse that sets the wakeup flag |
| bkreg_ready_in | input | 1 | Backup regulator ready from analog |
| mon_out_in | input | 1 | Supply monitor comparator output |
| flash_pd_stop | output | 1 | Flash power-down in stop |
| bkp_wr_en | output | 1 | Backup-domain write unlock |
| mon_level | output | 3 | Monitor threshold code |
| mon_en | output | 1 | Monitor enable |
| pd_deep | output | 1 | Power down on deep sleep |
| lp_stop | output | 1 | Low-power regulator in stop |
| bkreg_en | output | 1 | Backup regulator enable |
| wkpin_en | output | 1 | Wake-pin enable |
| stby_flag | output | 1 | Standby flag |
| wake_flag | output | 1 | Wakeup flag |

## Verification
The bench builds the block with the defaults `ADDR_W = 4` and `CLR_DELAY = 2`. With these values its accesses reach both mapped offsets, the two unmapped offsets 0x8 and 0xC, and the upper half-word addresses. The two-edge clear delay is short enough to sample the wakeup flag on every edge between the commit and the clear. Random word, half-word and byte accesses, with random sizes, offsets and analog inputs, run against a bench model. Directed sequences cover each reset domain, the write lock on the backup regulator enable and the same-edge set/clear priority.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;

    // control word bit positions
    localparam int C_LP_STOP  = 0;
    localparam int C_PD_DEEP  = 1;
    localparam int C_CLR_WU   = 2;
    localparam int C_CLR_SB   = 3;
    localparam int C_MON_EN   = 4;
    localparam int C_LVL_LO   = 5;
    localparam int C_BKP_WR   = 8;
    localparam int C_FLASH_PD = 9;

    // status word bit positions
    localparam int S_WU       = 0;
    localparam int S_SB       = 1;
    localparam int S_MON      = 2;
    localparam int S_RREADY   = 3;
    localparam int S_WKPIN    = 8;
    localparam int S_BKREG    = 9;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic {
        BUS_IDLE      = 1'b0,
        BUS_STAT_WAIT = 1'b1
    } bus_state_e;

    typedef enum logic {
        CLR_IDLE = 1'b0,
        CLR_PEND = 1'b1
    } clr_state_e;

    typedef struct packed {
        logic       flash_pd;
        logic       bkp_wr;
        logic [2:0] lvl;
        logic       mon_en;
        logic       pd_deep;
        logic       lp_stop;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[C_FLASH_PD]          = c.flash_pd;
        w[C_BKP_WR]            = c.bkp_wr;
        w[C_LVL_LO +: 3]       = c.lvl;
        w[C_MON_EN]            = c.mon_en;
        w[C_PD_DEEP]           = c.pd_deep;
        w[C_LP_STOP]           = c.lp_stop;
        return w;
    endfunction

endpackage

// File: rtl/pcr_bus_fsm.sv
module pcr_bus_fsm
    import pcr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic access,
    input  logic stat_rd,
    output logic ready
);
    bus_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= BUS_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        ready   = 1'b0;
        unique case (state_q)
            BUS_IDLE: begin
                if (access && stat_rd) begin
                    state_d = BUS_STAT_WAIT;
                end else begin
                    ready = access;
                end
            end
            BUS_STAT_WAIT: begin
                ready   = 1'b1;
                state_d = BUS_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/pcr_ctrl_reg.sv
module pcr_ctrl_reg
    import pcr_pkg::*;
(
    input  logic        clk,
    input  logic        por_rst,
    input  logic        sys_rst,
    input  logic        stby_rst,
    input  logic        we,
    input  logic [9:0]  wdata,
    output ctrl_t       ctrl
);
    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (por_rst || sys_rst || stby_rst) begin
            ctrl_q <= '0;
        end else if (we) begin
            ctrl_q.flash_pd <= wdata[C_FLASH_PD];
            ctrl_q.bkp_wr   <= wdata[C_BKP_WR];
            ctrl_q.lvl      <= wdata[C_LVL_LO +: 3];
            ctrl_q.mon_en   <= wdata[C_MON_EN];
            ctrl_q.pd_deep  <= wdata[C_PD_DEEP];
            ctrl_q.lp_stop  <= wdata[C_LP_STOP];
        end
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/pcr_flag_unit.sv
module pcr_flag_unit
    import pcr_pkg::*;
#(
    parameter int CLR_DELAY = 2
) (
    input  logic clk,
    input  logic por_rst,
    input  logic sys_rst,
    input  logic stat_we,
    input  logic wd_bkreg,
    input  logic wd_wkpin,
    input  logic unlock,
    input  logic clr_sb_cmd,
    input  logic clr_wu_cmd,
    input  logic set_standby,
    input  logic set_wakeup,
    output logic bkreg_en,
    output logic wkpin_en,
    output logic stby_flag,
    output logic wake_flag
);
    localparam int CNT_W = (CLR_DELAY < 2) ? 1 : $clog2(CLR_DELAY);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLR_DELAY - 1);

    clr_state_e       clr_q, clr_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             fire;

    // backup regulator enable: power-on domain only, write locked
    always_ff @(posedge clk) begin
        if (por_rst)                 bkreg_en <= 1'b0;
        else if (stat_we && unlock)  bkreg_en <= wd_bkreg;
    end

    // wake-pin enable: system domain
    always_ff @(posedge clk) begin
        if (por_rst || sys_rst) wkpin_en <= 1'b0;
        else if (stat_we)       wkpin_en <= wd_wkpin;
    end

    // standby flag: power-on domain, set wins over clear
    always_ff @(posedge clk) begin
        if (por_rst)          stby_flag <= 1'b0;
        else if (set_standby) stby_flag <= 1'b1;
        else if (clr_sb_cmd)  stby_flag <= 1'b0;
    end

    // wakeup flag: system domain, delayed clear, set wins
    always_ff @(posedge clk) begin
        if (por_rst || sys_rst) wake_flag <= 1'b0;
        else if (set_wakeup)    wake_flag <= 1'b1;
        else if (fire)          wake_flag <= 1'b0;
    end

    // delayed-clear state register
    always_ff @(posedge clk) begin
        if (por_rst || sys_rst) begin
            clr_q <= CLR_IDLE;
            cnt_q <= '0;
        end else begin
            clr_q <= clr_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        clr_d = clr_q;
        cnt_d = cnt_q;
        fire  = 1'b0;
        unique case (clr_q)
            CLR_IDLE: begin
                if (clr_wu_cmd) begin
                    clr_d = CLR_PEND;
                    cnt_d = '0;
                end
            end
            CLR_PEND: begin
                if (clr_wu_cmd) begin
                    cnt_d = '0;
                end else if (cnt_q == CNT_LAST) begin
                    fire  = 1'b1;
                    clr_d = CLR_IDLE;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/pcr_bank.sv
module pcr_bank
    import pcr_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CLR_DELAY = 2
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic              sys_rst,
    input  logic              stby_rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [1:0]        psize,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    input  logic              set_standby,
    input  logic              set_wakeup,
    input  logic              bkreg_ready_in,
    input  logic              mon_out_in,
    output logic              flash_pd_stop,
    output logic              bkp_wr_en,
    output logic [2:0]        mon_level,
    output logic              mon_en,
    output logic              pd_deep,
    output logic              lp_stop,
    output logic              bkreg_en,
    output logic              wkpin_en,
    output logic              stby_flag,
    output logic              wake_flag
);
    localparam int WORD_A_W = ADDR_W - 2;
    localparam logic [WORD_A_W-1:0] IDX_CTRL = WORD_A_W'(0);
    localparam logic [WORD_A_W-1:0] IDX_STAT = WORD_A_W'(1);

    logic        access, commit, hit_ctrl, hit_stat, lo_lane;
    logic        ctrl_we, stat_we, clr_sb_cmd, clr_wu_cmd;
    ctrl_t       ctrl;
    logic [31:0] stat_word;
    logic        unused_bits;

    assign access   = psel && penable;
    assign hit_ctrl = (paddr[ADDR_W-1:2] == IDX_CTRL);
    assign hit_stat = (paddr[ADDR_W-1:2] == IDX_STAT);
    assign lo_lane  = (paddr[1:0] == 2'b00) &&
                      ((size_e'(psize) == SZ_WORD) || (size_e'(psize) == SZ_HALF));

    pcr_bus_fsm u_bus (
        .clk     (clk),
        .rst     (por_rst),
        .access  (access),
        .stat_rd (!pwrite && hit_stat),
        .ready   (pready)
    );

    assign commit     = pready && access && pwrite && lo_lane;
    assign ctrl_we    = commit && hit_ctrl;
    assign stat_we    = commit && hit_stat;
    assign clr_sb_cmd = ctrl_we && pwdata[C_CLR_SB];
    assign clr_wu_cmd = ctrl_we && pwdata[C_CLR_WU];

    pcr_ctrl_reg u_ctrl (
        .clk      (clk),
        .por_rst  (por_rst),
        .sys_rst  (sys_rst),
        .stby_rst (stby_rst),
        .we       (ctrl_we),
        .wdata    (pwdata[9:0]),
        .ctrl     (ctrl)
    );

    pcr_flag_unit #(.CLR_DELAY(CLR_DELAY)) u_flags (
        .clk         (clk),
        .por_rst     (por_rst),
        .sys_rst     (sys_rst),
        .stat_we     (stat_we),
        .wd_bkreg    (pwdata[S_BKREG]),
        .wd_wkpin    (pwdata[S_WKPIN]),
        .unlock      (ctrl.bkp_wr),
        .clr_sb_cmd  (clr_sb_cmd),
        .clr_wu_cmd  (clr_wu_cmd),
        .set_standby (set_standby),
        .set_wakeup  (set_wakeup),
        .bkreg_en    (bkreg_en),
        .wkpin_en    (wkpin_en),
        .stby_flag   (stby_flag),
        .wake_flag   (wake_flag)
    );

    always_comb begin
        stat_word           = '0;
        stat_word[S_BKREG]  = bkreg_en;
        stat_word[S_WKPIN]  = wkpin_en;
        stat_word[S_RREADY] = bkreg_ready_in;
        stat_word[S_MON]    = mon_out_in && ctrl.mon_en;
        stat_word[S_SB]     = stby_flag;
        stat_word[S_WU]     = wake_flag;
    end

    always_comb begin
        if (hit_ctrl)      prdata = pack_ctrl(ctrl);
        else if (hit_stat) prdata = stat_word;
        else               prdata = '0;
    end

    assign flash_pd_stop = ctrl.flash_pd;
    assign bkp_wr_en     = ctrl.bkp_wr;
    assign mon_level     = ctrl.lvl;
    assign mon_en        = ctrl.mon_en;
    assign pd_deep       = ctrl.pd_deep;
    assign lp_stop       = ctrl.lp_stop;

    assign unused_bits = ^{pwdata[31:10], pwdata[7:4]};
endmodule

// File: rtl/pcr_bank_chk.sv
module pcr_bank_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              por_rst,
    input logic              sys_rst,
    input logic              stby_rst,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [1:0]        psize,
    input logic [31:0]       pwdata,
    input logic [31:0]       prdata,
    input logic              pready,
    input logic              set_standby,
    input logic              set_wakeup,
    input logic              bkreg_ready_in,
    input logic              mon_out_in,
    input logic              flash_pd_stop,
    input logic              bkp_wr_en,
    input logic [2:0]        mon_level,
    input logic              mon_en,
    input logic              pd_deep,
    input logic              lp_stop,
    input logic              bkreg_en,
    input logic              wkpin_en,
    input logic              stby_flag,
    input logic              wake_flag
);
    logic is_stat, is_ctrl, rd_done, wr_lo;
    assign is_stat = ((paddr >> 2) == 1);
    assign is_ctrl = ((paddr >> 2) == 0);
    assign rd_done = psel && penable && !pwrite && pready;
    assign wr_lo   = psel && penable && pwrite && pready && (paddr[1:0] == 2'b00) &&
                     (psize == 2'd1 || psize == 2'd2);

    // R2: upper bits and command bits read zero
    assert_ctrl_rd_zero_R2: assert property (@(posedge clk) disable iff (por_rst)
        (rd_done && is_ctrl) |-> (prdata[31:10] == '0 && prdata[3:2] == 2'b00));

    // R4: locked backup regulator enable holds
    assert_bkreg_locked_R4: assert property (@(posedge clk) disable iff (por_rst)
        !bkp_wr_en |=> $stable(bkreg_en));

    // R5: clear-standby command with no set
    assert_clr_sb_R5: assert property (@(posedge clk) disable iff (por_rst)
        (wr_lo && is_ctrl && pwdata[3] && !set_standby) |=> !stby_flag);

    // R7: system reset keeps standby flag, clears wakeup flag
    assert_sys_keep_sb_R7: assert property (@(posedge clk) disable iff (por_rst)
        (sys_rst && !set_standby && !(wr_lo && is_ctrl)) |=> (stby_flag == $past(stby_flag)));
    assert_sys_clr_wu_R7: assert property (@(posedge clk) disable iff (por_rst)
        sys_rst |=> !wake_flag);

    // R9: monitor output gated by enable
    assert_mon_gate_R9: assert property (@(posedge clk) disable iff (por_rst)
        (rd_done && is_stat && !mon_en) |-> !prdata[2]);

    // R10: status read waits exactly one cycle
    assert_stat_wait_R10: assert property (@(posedge clk) disable iff (por_rst)
        (psel && penable && !pwrite && is_stat && $past(psel && !penable)) |-> !pready);
    assert_stat_done_R10: assert property (@(posedge clk) disable iff (por_rst)
        (psel && penable && !pwrite && is_stat && !pready) |=> pready);
endmodule

bind pcr_bank pcr_bank_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/pcr_bank_tb.sv
module pcr_bank_tb;
    logic        clk = 1'b0;
    logic        por_rst = 1'b1, sys_rst = 1'b0, stby_rst = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [3:0]  paddr = '0;
    logic [1:0]  psize = 2'd2;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        set_standby = 1'b0, set_wakeup = 1'b0;
    logic        bkreg_ready_in = 1'b0, mon_out_in = 1'b0;
    logic        flash_pd_stop, bkp_wr_en, mon_en, pd_deep, lp_stop;
    logic [2:0]  mon_level;
    logic        bkreg_en, wkpin_en, stby_flag, wake_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pcr_bank #(.ADDR_W(4), .CLR_DELAY(2)) u_dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d, input logic [1:0] sz);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d; psize = sz;
        @(negedge clk);
        penable = 1'b1;
        #1;
        while (!pready) begin @(negedge clk); #1; end
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d, output int waits);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a; psize = 2'd2;
        @(negedge clk);
        penable = 1'b1;
        waits = 0;
        #1;
        while (!pready) begin waits++; @(negedge clk); #1; end
        d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: por_rst = 1'b1;
            1: sys_rst = 1'b1;
            2: stby_rst = 1'b1;
            3: set_standby = 1'b1;
            default: set_wakeup = 1'b1;
        endcase
        @(negedge clk);
        por_rst = 1'b0; sys_rst = 1'b0; stby_rst = 1'b0;
        set_standby = 1'b0; set_wakeup = 1'b0;
    endtask

    // bench model
    logic [9:0] m_ctrl;
    logic       m_bkre, m_wkp;

    function automatic logic [31:0] exp_ctrl();
        return {22'd0, m_ctrl & 10'h3F3};
    endfunction

    function automatic logic [31:0] exp_stat(input logic rr, input logic mo);
        logic [31:0] w;
        w = '0;
        w[9] = m_bkre; w[8] = m_wkp; w[3] = rr; w[2] = mo & m_ctrl[4];
        return w;
    endfunction

    function automatic logic [31:0] exp_read(input logic [3:0] a, input logic rr, input logic mo);
        if (a[3:2] == 2'd0) return exp_ctrl();
        if (a[3:2] == 2'd1) return exp_stat(rr, mo);
        return 32'd0;
    endfunction

    task automatic model_wr(input logic [3:0] a, input logic [31:0] d, input logic [1:0] sz);
        if ((sz == 2'd1 || sz == 2'd2) && a[1:0] == 2'b00) begin
            if (a[3:2] == 2'd0) m_ctrl = d[9:0] & 10'h3F3;
            else if (a[3:2] == 2'd1) begin
                if (m_ctrl[8]) m_bkre = d[9];
                m_wkp = d[8];
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int w;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        por_rst = 1'b0;

        // R1: reset state
        bus_rd(4'h0, rd, w); chk(rd == 0, "R1 ctrl reset", rd, 0);
        bus_rd(4'h4, rd, w); chk(rd == 0, "R1 stat reset", rd, 0);
        bus_rd(4'h8, rd, w); chk(rd == 0, "R1 unmapped", rd, 0);
        chk({flash_pd_stop, bkp_wr_en, mon_level, mon_en, pd_deep, lp_stop,
             bkreg_en, wkpin_en, stby_flag, wake_flag} == 0, "R1 outputs", 0, 0);

        // R2: layout and zero bits
        bus_wr(4'h0, 32'hFFFF_FFFF, 2'd2);
        bus_rd(4'h0, rd, w); chk(rd == 32'h3F3, "R2 readback", rd, 32'h3F3);
        chk({flash_pd_stop, bkp_wr_en, mon_level, mon_en, pd_deep, lp_stop} == 8'hFF,
            "R2 outputs", {24'd0, flash_pd_stop, bkp_wr_en, mon_level, mon_en, pd_deep, lp_stop}, 32'hFF);
        bus_wr(4'h0, 32'h0000_00A2, 2'd2);
        chk(mon_level == 3'd5 && pd_deep && !lp_stop && !mon_en, "R2 fields",
            {27'd0, mon_level, pd_deep, lp_stop}, {27'd0, 3'd5, 2'b10});

        // R10: wait states
        bus_rd(4'h4, rd, w); chk(w == 1, "R10 stat wait", w, 1);
        bus_rd(4'h0, rd, w); chk(w == 0, "R10 ctrl no wait", w, 0);

        // R3: half, upper half, byte, misaligned
        bus_wr(4'h0, 32'hFFFF_0011, 2'd1);
        bus_rd(4'h0, rd, w); chk(rd == 32'h11, "R3 half low", rd, 32'h11);
        bus_wr(4'h2, 32'hFFFF_FFFF, 2'd1);
        bus_rd(4'h0, rd, w); chk(rd == 32'h11, "R3 half high", rd, 32'h11);
        bus_wr(4'h0, 32'h0000_03FF, 2'd0);
        bus_rd(4'h0, rd, w); chk(rd == 32'h11, "R3 byte ignored", rd, 32'h11);
        bus_wr(4'h1, 32'h0000_03FF, 2'd2);
        bus_rd(4'h0, rd, w); chk(rd == 32'h11, "R3 misaligned", rd, 32'h11);

        // R4: write lock on backup regulator enable
        bus_wr(4'h0, 32'h0, 2'd2);
        bus_wr(4'h4, 32'h200, 2'd2);
        chk(!bkreg_en, "R4 locked", bkreg_en, 0);
        bus_wr(4'h0, 32'h100, 2'd2);
        bus_wr(4'h4, 32'h300, 2'd2);
        chk(bkreg_en && wkpin_en, "R4 unlocked", {bkreg_en, wkpin_en}, 2'b11);
        bus_wr(4'h0, 32'h0, 2'd2);
        bus_wr(4'h4, 32'h000, 2'd2);
        chk(bkreg_en && !wkpin_en, "R4 relocked", {bkreg_en, wkpin_en}, 2'b10);

        // R5 / R11: standby flag
        pulse(3); chk(stby_flag, "R11 set standby", stby_flag, 1);
        bus_wr(4'h0, 32'h4, 2'd2); chk(stby_flag, "R5 zero no effect", stby_flag, 1);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 4'h0; pwdata = 32'h8; psize = 2'd2;
        @(negedge clk); penable = 1'b1; set_standby = 1'b1;
        @(negedge clk); psel = 1'b0; penable = 1'b0; set_standby = 1'b0;
        chk(stby_flag, "R11 set beats clear", stby_flag, 1);
        bus_wr(4'h0, 32'h8, 2'd2); chk(!stby_flag, "R5 clear", stby_flag, 0);

        // R6: delayed wakeup clear
        pulse(4); chk(wake_flag, "R11 set wakeup", wake_flag, 1);
        bus_wr(4'h0, 32'h4, 2'd2);
        chk(wake_flag, "R6 edge+0", wake_flag, 1);
        @(negedge clk); chk(wake_flag, "R6 edge+1", wake_flag, 1);
        @(negedge clk); chk(!wake_flag, "R6 edge+2", wake_flag, 0);

        // R7: system reset domain
        bus_wr(4'h0, 32'h1B3, 2'd2);
        bus_wr(4'h4, 32'h300, 2'd2);
        pulse(3); pulse(4);
        pulse(1);
        bus_rd(4'h0, rd, w); chk(rd == 0, "R7 ctrl cleared", rd, 0);
        chk(!wkpin_en && !wake_flag && stby_flag && bkreg_en, "R7 domains",
            {wkpin_en, wake_flag, stby_flag, bkreg_en}, 4'b0011);

        // R8: standby-exit reset domain
        bus_wr(4'h0, 32'h1B3, 2'd2);
        bus_wr(4'h4, 32'h300, 2'd2);
        pulse(4);
        pulse(2);
        bus_rd(4'h0, rd, w); chk(rd == 0, "R8 ctrl cleared", rd, 0);
        chk(wkpin_en && wake_flag && stby_flag && bkreg_en, "R8 status kept",
            {wkpin_en, wake_flag, stby_flag, bkreg_en}, 4'b1111);

        // R9: monitor gating and regulator ready
        mon_out_in = 1'b1; bkreg_ready_in = 1'b1;
        bus_rd(4'h4, rd, w); chk(rd[3:2] == 2'b10 && rd[7:4] == 0, "R9 mon gated", rd, 32'h8);
        bus_wr(4'h0, 32'h10, 2'd2);
        bus_rd(4'h4, rd, w); chk(rd[3:2] == 2'b11, "R9 mon shown", rd[3:0], 4'hC);

        // R1: power-on reset clears the regulator enable
        pulse(0);
        chk(!bkreg_en && !stby_flag, "R1 por clears all", {bkreg_en, stby_flag}, 0);

        // random phase against model (R2 R3 R4 R9 R10)
        m_ctrl = '0; m_bkre = 1'b0; m_wkp = 1'b0;
        for (int i = 0; i < 300; i++) begin
            logic [3:0]  a;
            logic [31:0] d;
            logic [1:0]  sz;
            a  = 4'($urandom_range(0, 15)) & 4'hE;
            d  = $urandom;
            sz = 2'($urandom_range(0, 3));
            if (($urandom & 3) == 0) a[1:0] = 2'b00;
            mon_out_in = 1'($urandom); bkreg_ready_in = 1'($urandom);
            if ($urandom & 1) begin
                if (a[3:2] == 2'd1 && ($urandom & 1)) d[9] = 1'b1;
                bus_wr(a, d, sz);
                model_wr(a, d, sz);
                chk({flash_pd_stop, bkp_wr_en, mon_level, mon_en, pd_deep, lp_stop,
                     bkreg_en, wkpin_en} == {m_ctrl[9:4], m_ctrl[1:0], m_bkre, m_wkp},
                    "R3 R4 random write", {22'd0, flash_pd_stop, bkp_wr_en, mon_level, mon_en,
                    pd_deep, lp_stop, bkreg_en, wkpin_en},
                    {22'd0, m_ctrl[9:4], m_ctrl[1:0], m_bkre, m_wkp});
            end else begin
                bus_rd(a, rd, w);
                chk(rd == exp_read(a, bkreg_ready_in, mon_out_in), "R2 R9 random read",
                    rd, exp_read(a, bkreg_ready_in, mon_out_in));
                chk(w == ((a[3:2] == 2'd1) ? 1 : 0), "R10 random wait", w,
                    (a[3:2] == 2'd1) ? 1 : 0);
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule